// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block is the tag and permission directory of a set-associative cache. It stores line addresses and a two-bit access permission for every way of every set. Data storage and coherence state machines are outside it. A controller sends one command per cycle: access check, presence test, availability test, allocate, deallocate, victim probe, permission read, permission write or mark-as-most-recently-used. The response is registered and appears one cycle later.

Each set keeps a true-LRU order, held as one age counter per way, to pick replacement victims. A way counts as free when it is empty or its permission is "not present". A hit needs both a live tag match and a permission that covers the request type. The number of sets, the associativity, the address width and the line-offset width are parameters.

Top module: `tag_directory`

## Requirements
- R1: The set index is reqAddr[OFF_W +: log2(SETS)]. A command only reads or changes the set that its address selects, so the same upper bits in another set are a different line.
- R2: A way matches only when it is occupied, its stored line address equals reqAddr, and its permission is not "not present" (00). Presence test (op 1) reports rspHit=1 only on such a match.
- R3: Access (op 0) hits when the matched permission is read-write (11) for any request type. It also hits when the matched permission is read-only (10) and reqKind is load (00) or fetch (01). rspPerm returns the matched permission.
- R4: An access that is a store (reqKind 10) to a read-only line, or any access to an invalid (01) line, misses even though the tag matched.
- R5: Every access with a tag match makes that way most recently used, whether it hits or not.
- R6: Availability test (op 2) reports rspHit=1 when the set already holds the address, or when any way of the set is empty or "not present".
- R7: Allocate (op 3) writes the line into the lowest-numbered free way, sets its permission to invalid (01) and makes it most recently used. It responds with rspHit=1 and rspWay set to that way.
- R8: Allocate to a set with no free way responds with rspErr=1 and rspHit=0 and changes no state.
- R9: Deallocate (op 4) empties the matched way (rspHit=1, rspWay=that way). A later presence test for that line misses.
- R10: Victim probe (op 5) returns in rspAddr the line address, and in rspWay the index, of the least recently used way of the set. rspErr=1 when the set still has a free way.
- R11: Permission read (op 6) returns the matched way's permission, or 00 with rspHit=0 on no match. Permission write (op 7) replaces it with reqPerm. Writing 00 frees the way for allocation.
- R12: Mark-MRU (op 8) makes the matched way most recently used without changing its tag or permission.
- R13: rspValid is 1 exactly one cycle after a cycle with reqValid=1. After reset every way is empty and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Command present this cycle |
| reqOp | input | 4 | Command code (0 to 8, see requirements) |
| reqKind | input | 2 | Request type: 00 load, 01 fetch, 10 store |
| reqPerm | input | 2 | New permission for a permission write |
| reqAddr | input | ADDR_W | Line-aligned request address |
| rspValid | output | 1 | Response present |
| rspHit | output | 1 | Hit, match or success of the command |
| rspErr | output | 1 | Allocate with no free way, or probe of a set with a free way |
| rspPerm | output | 2 | Matched permission (access, permission read) |
| rspWay | output | log2(WAYS) | Way matched, allocated or chosen as victim |
| rspAddr | output | ADDR_W | Victim line address on probe, else the request address |

## Verification
Two functions can fall in the same cycle. An access with a tag match reports a hit or a miss, and in that same cycle it reorders the replacement state. An allocate writes a tag and also moves its way to most recently used. The bench provokes both with stores to invalid and read-only lines and with fills into a set that has holes. It judges the side effect through a victim probe issued in the next command. This shows that a missing access still moved its way away from the victim slot.

// File: rtl/tdir_pkg.sv
package tdir_pkg;

  typedef enum logic [3:0] {
    OP_ACCESS  = 4'd0,
    OP_PRESENT = 4'd1,
    OP_AVAIL   = 4'd2,
    OP_ALLOC   = 4'd3,
    OP_DEALLOC = 4'd4,
    OP_PROBE   = 4'd5,
    OP_GETPERM = 4'd6,
    OP_SETPERM = 4'd7,
    OP_TOUCH   = 4'd8
  } op_e;

  localparam logic [1:0] PERM_NONE    = 2'b00;
  localparam logic [1:0] PERM_INVALID = 2'b01;
  localparam logic [1:0] PERM_RO      = 2'b10;
  localparam logic [1:0] PERM_RW      = 2'b11;

  localparam logic [1:0] KIND_LOAD  = 2'b00;
  localparam logic [1:0] KIND_FETCH = 2'b01;
  localparam logic [1:0] KIND_STORE = 2'b10;

  // strobes from control to datapath, all aimed at one way of the addressed set
  typedef struct packed {
    logic touch;
    logic fill;
    logic clear;
    logic setPerm;
  } strobe_t;

endpackage

// File: rtl/tdir_lru.sv
module tdir_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  logic             touch,
  input  logic [WAY_W-1:0] touchWay,
  output logic [WAY_W-1:0] victimWay
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // age 0 = most recent, WAYS-1 = least recent; ages of a set form a permutation
  logic [WAY_W-1:0] age [SETS][WAYS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touchWay)
          age[setIdx][w] <= '0;
        else if (age[setIdx][w] < age[setIdx][touchWay])
          age[setIdx][w] <= age[setIdx][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victimWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[setIdx][w] == OLDEST) victimWay = WAY_W'(w);
  end

endmodule

// File: rtl/tdir_datapath.sv
module tdir_datapath
  import tdir_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  strobe_t           strobe,
  input  logic [WAY_W-1:0]  cmdWay,
  input  logic [1:0]        cmdPerm,
  output logic              tagEq   [WAYS],
  output logic              occVec  [WAYS],
  output logic [1:0]        permVec [WAYS],
  output logic [WAY_W-1:0]  victimWay,
  output logic [ADDR_W-1:0] victimAddr
);

  logic [SET_W-1:0] setIdx;
  logic [TAG_W-1:0] reqTag;

  assign setIdx = reqAddr[OFF_W +: SET_W];
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];

  logic [TAG_W-1:0] tagMem  [SETS][WAYS];
  logic             occMem  [SETS][WAYS];
  logic [1:0]       permMem [SETS][WAYS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w]  <= '0;
          occMem[s][w]  <= 1'b0;
          permMem[s][w] <= PERM_NONE;
        end
    end else begin
      if (strobe.fill) begin
        tagMem[setIdx][cmdWay]  <= reqTag;
        occMem[setIdx][cmdWay]  <= 1'b1;
        permMem[setIdx][cmdWay] <= PERM_INVALID;
      end else if (strobe.clear) begin
        occMem[setIdx][cmdWay]  <= 1'b0;
        permMem[setIdx][cmdWay] <= PERM_NONE;
      end else if (strobe.setPerm) begin
        permMem[setIdx][cmdWay] <= cmdPerm;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign occVec[w]  = occMem[setIdx][w];
    assign permVec[w] = permMem[setIdx][w];
    assign tagEq[w]   = occMem[setIdx][w] && (tagMem[setIdx][w] == reqTag);
  end

  tdir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk      (clk),
    .rstN     (rstN),
    .setIdx   (setIdx),
    .touch    (strobe.touch),
    .touchWay (cmdWay),
    .victimWay(victimWay)
  );

  assign victimAddr = {tagMem[setIdx][victimWay], setIdx, {OFF_W{1'b0}}};

endmodule

// File: rtl/tdir_ctrl.sv
module tdir_ctrl
  import tdir_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqPerm,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              tagEq   [WAYS],
  input  logic              occVec  [WAYS],
  input  logic [1:0]        permVec [WAYS],
  input  logic [WAY_W-1:0]  victimWay,
  input  logic [ADDR_W-1:0] victimAddr,
  output strobe_t           strobe,
  output logic [WAY_W-1:0]  cmdWay,
  output logic [1:0]        cmdPerm,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspErr,
  output logic [1:0]        rspPerm,
  output logic [WAY_W-1:0]  rspWay,
  output logic [ADDR_W-1:0] rspAddr
);

  logic             matchAny, freeAny, anyTag;
  logic [WAY_W-1:0] matchWay, freeWay;
  logic [1:0]       matchPerm;

  // lowest live match and lowest free way in the addressed set
  always_comb begin
    matchAny = 1'b0;
    matchWay = '0;
    freeAny  = 1'b0;
    freeWay  = '0;
    anyTag   = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (tagEq[w]) anyTag = 1'b1;
      if (tagEq[w] && permVec[w] != PERM_NONE) begin
        matchAny = 1'b1;
        matchWay = WAY_W'(w);
      end
      if (!occVec[w] || permVec[w] == PERM_NONE) begin
        freeAny = 1'b1;
        freeWay = WAY_W'(w);
      end
    end
    matchPerm = matchAny ? permVec[matchWay] : PERM_NONE;
  end

  logic             nxtHit, nxtErr;
  logic [1:0]       nxtPerm;
  logic [WAY_W-1:0] nxtWay;
  logic [ADDR_W-1:0] nxtAddr;
  strobe_t          stb;

  always_comb begin
    stb     = '0;
    nxtHit  = 1'b0;
    nxtErr  = 1'b0;
    nxtPerm = PERM_NONE;
    nxtWay  = matchWay;
    nxtAddr = reqAddr;
    unique case (op_e'(reqOp))
      OP_ACCESS: begin
        nxtHit    = matchAny && (matchPerm == PERM_RW ||
                                 (matchPerm == PERM_RO && reqKind != KIND_STORE));
        nxtPerm   = matchPerm;
        stb.touch = matchAny;
      end
      OP_PRESENT: nxtHit = matchAny;
      OP_AVAIL: begin
        nxtHit = anyTag || freeAny;
        nxtWay = freeWay;
      end
      OP_ALLOC: begin
        nxtWay = freeWay;
        if (freeAny) begin
          stb.fill  = 1'b1;
          stb.touch = 1'b1;
          nxtHit    = 1'b1;
        end else begin
          nxtErr = 1'b1;
        end
      end
      OP_DEALLOC: begin
        nxtHit    = matchAny;
        stb.clear = matchAny;
      end
      OP_PROBE: begin
        nxtWay  = victimWay;
        nxtAddr = victimAddr;
        nxtErr  = freeAny;
        nxtHit  = !freeAny;
      end
      OP_GETPERM: begin
        nxtHit  = matchAny;
        nxtPerm = matchPerm;
      end
      OP_SETPERM: begin
        nxtHit      = matchAny;
        stb.setPerm = matchAny;
      end
      OP_TOUCH: begin
        nxtHit    = matchAny;
        stb.touch = matchAny;
      end
      default: nxtHit = 1'b0;
    endcase
  end

  assign strobe  = reqValid ? stb : '0;
  assign cmdWay  = nxtWay;
  assign cmdPerm = reqPerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspErr   <= 1'b0;
      rspPerm  <= PERM_NONE;
      rspWay   <= '0;
      rspAddr  <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= reqValid && nxtHit;
      rspErr   <= reqValid && nxtErr;
      rspPerm  <= reqValid ? nxtPerm : PERM_NONE;
      rspWay   <= reqValid ? nxtWay : '0;
      rspAddr  <= reqValid ? nxtAddr : '0;
    end
  end

endmodule

// File: rtl/tag_directory.sv
module tag_directory
  import tdir_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqPerm,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspErr,
  output logic [1:0]        rspPerm,
  output logic [WAY_W-1:0]  rspWay,
  output logic [ADDR_W-1:0] rspAddr
);

  strobe_t           strobe;
  logic [WAY_W-1:0]  cmdWay;
  logic [1:0]        cmdPerm;
  logic              tagEq   [WAYS];
  logic              occVec  [WAYS];
  logic [1:0]        permVec [WAYS];
  logic [WAY_W-1:0]  victimWay;
  logic [ADDR_W-1:0] victimAddr;

  tdir_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqAddr   (reqAddr),
    .strobe    (strobe),
    .cmdWay    (cmdWay),
    .cmdPerm   (cmdPerm),
    .tagEq     (tagEq),
    .occVec    (occVec),
    .permVec   (permVec),
    .victimWay (victimWay),
    .victimAddr(victimAddr)
  );

  tdir_ctrl #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqKind   (reqKind),
    .reqPerm   (reqPerm),
    .reqAddr   (reqAddr),
    .tagEq     (tagEq),
    .occVec    (occVec),
    .permVec   (permVec),
    .victimWay (victimWay),
    .victimAddr(victimAddr),
    .strobe    (strobe),
    .cmdWay    (cmdWay),
    .cmdPerm   (cmdPerm),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspErr    (rspErr),
    .rspPerm   (rspPerm),
    .rspWay    (rspWay),
    .rspAddr   (rspAddr)
  );

endmodule

// File: rtl/tdir_checker.sv
module tdir_checker
  import tdir_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [3:0] reqOp,
  input logic [1:0] reqKind,
  input logic       rspValid,
  input logic       rspHit,
  input logic       rspErr,
  input logic [1:0] rspPerm
);

  logic       prevValid;
  logic [3:0] prevOp;
  logic [1:0] prevKind;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevOp    <= 4'd0;
      prevKind  <= 2'd0;
    end else begin
      prevValid <= reqValid;
      prevOp    <= reqOp;
      prevKind  <= reqKind;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R13
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R13
  AST_HIT_NEEDS_PERM: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevOp == OP_ACCESS && rspHit) |-> (rspPerm == PERM_RO || rspPerm == PERM_RW)); // R3
  AST_STORE_RO_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevOp == OP_ACCESS && prevKind == KIND_STORE && rspPerm == PERM_RO) |-> !rspHit); // R4
  AST_ALLOC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevOp == OP_ALLOC) |-> (rspHit != rspErr)); // R7
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (prevValid && (prevOp == OP_ALLOC || prevOp == OP_PROBE))); // R8
  AST_GETPERM_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevOp == OP_GETPERM && !rspHit) |-> rspPerm == PERM_NONE); // R11

endmodule

bind tag_directory tdir_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqOp   (reqOp),
  .reqKind (reqKind),
  .rspValid(rspValid),
  .rspHit  (rspHit),
  .rspErr  (rspErr),
  .rspPerm (rspPerm)
);

// File: tb/tag_directory_bench.sv
module tag_directory_bench;

  localparam int ADDR_W = 32;
  localparam int OFF_W  = 6;
  localparam int SETS   = 16;
  localparam int WAYS   = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [3:0]        reqOp;
  logic [1:0]        reqKind;
  logic [1:0]        reqPerm;
  logic [ADDR_W-1:0] reqAddr;
  logic              rspValid, rspHit, rspErr;
  logic [1:0]        rspPerm;
  logic [1:0]        rspWay;
  logic [ADDR_W-1:0] rspAddr;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 0;

  always #10 clk = ~clk;

  tag_directory #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS)) u_tag_directory (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqKind(reqKind),
    .reqPerm(reqPerm), .reqAddr(reqAddr), .rspValid(rspValid), .rspHit(rspHit),
    .rspErr(rspErr), .rspPerm(rspPerm), .rspWay(rspWay), .rspAddr(rspAddr)
  );

  localparam logic [3:0] ACC = 0, PRES = 1, AVL = 2, ALC = 3, DEA = 4,
                         PRB = 5, GETP = 6, SETP = 7, TCH = 8;

  function automatic logic [ADDR_W-1:0] la(int s, int t);
    return ADDR_W'((t << (OFF_W + 4)) | (s << OFF_W));
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] op, logic [ADDR_W-1:0] a,
                       logic [1:0] kind = 2'b00, logic [1:0] perm = 2'b00);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqKind = kind; reqPerm = perm;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic tReset();
    chk("R13", "rspValid in reset", rspValid, 0);
    chk("R13", "rspHit in reset", rspHit, 0);
    chk("R13", "rspAddr in reset", rspAddr, 0);
  endtask

  task automatic tIdleAndEmpty();
    issue(PRES, la(3, 10));
    chk("R13", "rspValid after request", rspValid, 1);
    chk("R2", "present on empty", rspHit, 0);
    @(negedge clk);
    chk("R13", "rspValid idle", rspValid, 0);
    issue(AVL, la(3, 10));
    chk("R6", "avail on empty set", rspHit, 1);
  endtask

  task automatic tFillAndLru();
    for (int t = 10; t < 14; t++) begin
      issue(ALC, la(3, t));
      chk("R7", "alloc hit", rspHit, 1);
      chk("R7", "alloc way", rspWay, t - 10);
      chk("R7", "alloc err", rspErr, 0);
    end
    issue(PRB, la(3, 0));
    chk("R10", "probe addr", rspAddr, la(3, 10));
    chk("R10", "probe err full", rspErr, 0);
    issue(GETP, la(3, 10));
    chk("R7", "alloc perm invalid", rspPerm, 1);
    issue(TCH, la(3, 10));
    chk("R12", "touch hit", rspHit, 1);
    issue(PRB, la(3, 0));
    chk("R12", "victim after touch", rspAddr, la(3, 11));
    issue(ACC, la(3, 11), 2'b10);
    chk("R4", "store to invalid misses", rspHit, 0);
    chk("R4", "matched perm reported", rspPerm, 1);
    issue(PRB, la(3, 0));
    chk("R5", "missing access updates LRU", rspAddr, la(3, 12));
  endtask

  task automatic tPerms();
    issue(SETP, la(3, 10), 2'b00, 2'b10);
    chk("R11", "setperm hit", rspHit, 1);
    issue(ACC, la(3, 10), 2'b00);
    chk("R3", "load RO hit", rspHit, 1);
    issue(ACC, la(3, 10), 2'b01);
    chk("R3", "fetch RO hit", rspHit, 1);
    issue(ACC, la(3, 10), 2'b10);
    chk("R4", "store RO miss", rspHit, 0);
    chk("R4", "store RO perm", rspPerm, 2);
    issue(SETP, la(3, 10), 2'b00, 2'b11);
    issue(ACC, la(3, 10), 2'b10);
    chk("R3", "store RW hit", rspHit, 1);
    issue(ACC, la(3, 12), 2'b00);
    chk("R4", "load invalid miss", rspHit, 0);
    issue(PRB, la(3, 0));
    chk("R5", "victim after accesses", rspAddr, la(3, 13));
    chk("R10", "probe way", rspWay, 3);
  endtask

  task automatic tFull();
    issue(AVL, la(3, 99));
    chk("R6", "avail full set new tag", rspHit, 0);
    issue(AVL, la(3, 12));
    chk("R6", "avail present tag", rspHit, 1);
    issue(ALC, la(3, 99));
    chk("R8", "alloc full err", rspErr, 1);
    chk("R8", "alloc full hit", rspHit, 0);
    issue(PRES, la(3, 99));
    chk("R8", "failed alloc not present", rspHit, 0);
    issue(PRB, la(3, 0));
    chk("R8", "victim unchanged", rspAddr, la(3, 13));
  endtask

  task automatic tDealloc();
    issue(DEA, la(3, 11));
    chk("R9", "dealloc hit", rspHit, 1);
    chk("R9", "dealloc way", rspWay, 1);
    issue(DEA, la(3, 13));
    chk("R9", "dealloc way 3", rspWay, 3);
    issue(PRES, la(3, 11));
    chk("R9", "present after dealloc", rspHit, 0);
    issue(PRB, la(3, 0));
    chk("R10", "probe with hole err", rspErr, 1);
    issue(AVL, la(3, 99));
    chk("R6", "avail with hole", rspHit, 1);
    issue(ALC, la(3, 50));
    chk("R7", "alloc lowest free", rspWay, 1);
    issue(ALC, la(3, 51));
    chk("R7", "alloc next free", rspWay, 3);
    issue(PRB, la(3, 0));
    chk("R10", "probe after refill", rspAddr, la(3, 10));
  endtask

  task automatic tNotPresent();
    issue(SETP, la(3, 12), 2'b00, 2'b00);
    issue(PRES, la(3, 12));
    chk("R2", "not-present line misses", rspHit, 0);
    issue(GETP, la(3, 12));
    chk("R11", "getperm miss hit", rspHit, 0);
    chk("R11", "getperm miss perm", rspPerm, 0);
    issue(ALC, la(3, 77));
    chk("R11", "alloc into not-present way", rspWay, 2);
    chk("R11", "alloc ok", rspHit, 1);
    issue(PRB, la(3, 0));
    chk("R10", "probe after np alloc", rspAddr, la(3, 10));
  endtask

  task automatic tSets();
    issue(PRES, la(5, 10));
    chk("R1", "same tag other set", rspHit, 0);
    issue(PRB, la(5, 0));
    chk("R1", "other set has free ways", rspErr, 1);
    issue(ALC, la(5, 10));
    chk("R1", "other set alloc way0", rspWay, 0);
    issue(PRES, la(3, 10));
    chk("R1", "set 3 line intact", rspHit, 1);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqKind = '0; reqPerm = '0; reqAddr = '0;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tIdleAndEmpty();
    tFillAndLru();
    tPerms();
    tFull();
    tDealloc();
    tNotPresent();
    tSets();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++;
      nFail++;
      $display("FAIL R13 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule